// File: doc/BRIEF.md
# Seconds-Based Real-Time Clock with Alarms and Countdown

This block keeps wall time from a slow clock enable that pulses at 32.768 kHz inside the fast system clock domain. A divider turns those pulses into one tick per second. The tick advances four chained counters: seconds, minutes, hours and a free-running 15-bit day count. A test bit bypasses the divider so that every enable pulse counts as one full second.

Seven event sources share one sticky status register:
- four tick events, one each for a new second, minute, hour and day;
- a countdown stopwatch with one-second resolution;
- a time-of-day alarm;
- a day-plus-time alarm.

Each source has its own enable bit. The interrupt line is a level that stays high while any enabled status bit is set. A single-cycle wake pulse marks the moment an enabled event happens. Software reaches the block through a flat write strobe, an address, write data and a combinational read-data bus.

Top module: `rtc_core`

## Requirements
- R1: After reset the time, alarm, stopwatch, enable and status registers read zero, the control register reads 1 (divider on, stopwatch off), and `irq` and `wake` are low.
- R2: Register map by `addr`:
  - 0 = time, packed as day[31:17], hour[16:12], minute[11:6], second[5:0];
  - 1 = alarm, same packing;
  - 2 = stopwatch count [15:0];
  - 3 = control, where bit0 is the divider enable and bit1 is the stopwatch run bit;
  - 4 = interrupt enable;
  - 5 = status.
  
  With control bit0 set, the second advances exactly once per 32768 cycles in which `tick_en` is high.
- R3: With control bit0 clear, every cycle with `tick_en` high advances the time by one second.
- R4: Seconds and minutes count modulo 60 and hours modulo 24, each carrying into the next field; the day count carries from hours and wraps from 32767 to 0.
- R5: Status bit0 sets on every second tick. Bit1 sets when the seconds wrap, bit2 when the minutes wrap, and bit3 when the hours wrap.
- R6: Status bit5 sets when a second tick makes hour, minute and second equal to the alarm register, whatever the day.
- R7: Status bit6 sets only when a second tick makes the day as well as hour, minute and second equal to the alarm register.
- R8: A write to the stopwatch loads it. While control bit1 is set, it drops by one on each second tick. On reaching zero it sets status bit4 and then stays at zero. While control bit1 is clear it holds.
- R9: Status bits are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the bit set.
- R10: `irq` is high exactly while some status bit and its matching enable bit (same bit position) are both set.
- R11: `wake` pulses high for one cycle after each clock edge at which an enabled event occurred. It stays low for events whose enable bit is clear.
- R12: A write to the time register in the same cycle as a second tick takes the written value. Writing the time register never triggers an alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational on `addr`) |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | One-cycle wakeup pulse |

## Verification
The bench drives a full cascade from 23:59:59 so that all four tick events fire on one edge. A carry chain that ripples late or misses a field would show up here. It drives the day count from its maximum through the wrap, where a wrong width or a compare against 32768 would stick or overflow into the hours. It writes the time register in the same cycle as a tick, and writes it to a value equal to the alarm; a design that let the increment win, or compared the register contents instead of the ticked value, would show a stale time or a spurious alarm. It holds the stopwatch past zero to catch an underflow wrap to 65535 or a repeated event. It clears a status bit in the cycle its event fires to catch clear-wins logic. It counts exactly 32767 and then 32768 divided pulses to catch an off-by-one divider.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef struct packed {
        logic [14:0] day;
        logic [4:0]  hour;
        logic [5:0]  min;
        logic [5:0]  sec;
    } rtc_time_t;

    localparam int unsigned NUM_EVT = 7;

    localparam logic [2:0] A_TIME  = 3'd0;
    localparam logic [2:0] A_ALARM = 3'd1;
    localparam logic [2:0] A_SWCH  = 3'd2;
    localparam logic [2:0] A_CTRL  = 3'd3;
    localparam logic [2:0] A_IEN   = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;

    localparam int unsigned E_SEC  = 0;
    localparam int unsigned E_MIN  = 1;
    localparam int unsigned E_HOUR = 2;
    localparam int unsigned E_DAY  = 3;
    localparam int unsigned E_SW   = 4;
    localparam int unsigned E_ALA  = 5;
    localparam int unsigned E_ALB  = 6;
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic div_on,
    output logic sec_tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        sec_tick = 1'b0;
        if (!div_on) begin
            s_d.cnt  = '0;
            sec_tick = tick_en;
        end else if (tick_en) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt  = '0;
                sec_tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t tm,
    output rtc_time_t tm_adv,
    output logic [3:0] roll
);
    rtc_time_t t_d, t_q;

    always_comb begin
        tm_adv = t_q;
        roll   = 4'b0;
        roll[0] = sec_tick;
        if (sec_tick) begin
            if (t_q.sec == 6'd59) begin
                tm_adv.sec = '0;
                roll[1] = 1'b1;
                if (t_q.min == 6'd59) begin
                    tm_adv.min = '0;
                    roll[2] = 1'b1;
                    if (t_q.hour == 5'd23) begin
                        tm_adv.hour = '0;
                        roll[3] = 1'b1;
                        tm_adv.day = t_q.day + 1'b1;
                    end else begin
                        tm_adv.hour = t_q.hour + 1'b1;
                    end
                end else begin
                    tm_adv.min = t_q.min + 1'b1;
                end
            end else begin
                tm_adv.sec = t_q.sec + 1'b1;
            end
        end
        t_d = load ? load_val : tm_adv;
        tm  = t_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         sec_tick,
    output logic [W-1:0] count,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } sw_st_t;

    sw_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (load) begin
            s_d.cnt = load_val;
        end else if (run && sec_tick && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
            expire  = (s_q.cnt == W'(1));
        end
        count = s_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned PRESCALE = 32768,
    parameter int unsigned SW_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        wake
);
    typedef struct packed {
        rtc_time_t          alarm;
        logic [1:0]         ctrl;
        logic [NUM_EVT-1:0] ien;
        logic [NUM_EVT-1:0] stat;
        logic               wake;
    } core_st_t;

    core_st_t r_d, r_q;

    logic               sec_tick;
    rtc_time_t          tm, tm_adv;
    logic [3:0]         roll;
    logic [SW_W-1:0]    sw_cnt;
    logic               sw_exp;
    logic               wr_time, wr_sw;
    logic [NUM_EVT-1:0] evt;

    assign wr_time = wr_en && (addr == A_TIME);
    assign wr_sw   = wr_en && (addr == A_SWCH);

    rtc_prescale #(.DIV(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .div_on   (r_q.ctrl[0]),
        .sec_tick (sec_tick)
    );

    rtc_timekeep u_tk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load     (wr_time),
        .load_val (rtc_time_t'(wdata)),
        .tm       (tm),
        .tm_adv   (tm_adv),
        .roll     (roll)
    );

    rtc_stopwatch #(.W(SW_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_sw),
        .load_val (wdata[SW_W-1:0]),
        .run      (r_q.ctrl[1]),
        .sec_tick (sec_tick),
        .count    (sw_cnt),
        .expire   (sw_exp)
    );

    always_comb begin
        logic hms_hit;
        hms_hit = (tm_adv.hour == r_q.alarm.hour) && (tm_adv.min == r_q.alarm.min) &&
                  (tm_adv.sec == r_q.alarm.sec);
        evt = '0;
        evt[E_DAY:E_SEC] = wr_time ? 4'b0 : roll;
        evt[E_SW]  = sw_exp;
        evt[E_ALA] = sec_tick && !wr_time && hms_hit;
        evt[E_ALB] = sec_tick && !wr_time && hms_hit && (tm_adv.day == r_q.alarm.day);

        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_ALARM: r_d.alarm = rtc_time_t'(wdata);
                A_CTRL:  r_d.ctrl  = wdata[1:0];
                A_IEN:   r_d.ien   = wdata[NUM_EVT-1:0];
                A_STAT:  r_d.stat  = r_q.stat & ~wdata[NUM_EVT-1:0];
                default: ;
            endcase
        end
        r_d.stat = r_d.stat | evt;
        r_d.wake = |(evt & r_d.ien);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ctrl <= 2'b01;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            A_TIME:  rdata = tm;
            A_ALARM: rdata = r_q.alarm;
            A_SWCH:  rdata = 32'(sw_cnt);
            A_CTRL:  rdata = 32'(r_q.ctrl);
            A_IEN:   rdata = 32'(r_q.ien);
            A_STAT:  rdata = 32'(r_q.stat);
            default: rdata = '0;
        endcase
    end

    assign irq  = |(r_q.stat & r_q.ien);
    assign wake = r_q.wake;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int unsigned SW_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      addr,
    input rtc_time_t       tm,
    input logic [SW_W-1:0] sw_cnt,
    input logic [NUM_EVT-1:0] ien,
    input logic            irq,
    input logic            wake
);
    p_field_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tm.sec < 6'd60) && (tm.min < 6'd60) && (tm.hour < 5'd24));

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_TIME) |=>
        (tm.sec == $past(tm.sec)) ||
        (tm.sec == (($past(tm.sec) == 6'd59) ? 6'd0 : $past(tm.sec) + 6'd1)));

    p_sw_stays_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cnt == '0) && !(wr_en && addr == A_SWCH) |=> (sw_cnt == '0));

    p_wake_has_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);

    p_no_enable_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

bind rtc_core rtc_core_chk #(.SW_W(SW_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .tm     (tm),
    .sw_cnt (sw_cnt),
    .ien    (r_q.ien),
    .irq    (irq),
    .wake   (wake)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, wake;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_core dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
    );

    function automatic logic [31:0] tpk(int d, int h, int m, int s);
        return {15'(d), 5'(h), 6'(m), 6'(s)};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 time", v, 0);
        rd(3'd1, v); chk("R1 alarm", v, 0);
        rd(3'd2, v); chk("R1 stopwatch", v, 0);
        rd(3'd3, v); chk("R1 ctrl", v, 1);
        rd(3'd5, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wake", wake, 0);
    endtask

    task automatic t_bypass();
        logic [31:0] v;
        wr(3'd3, 0);
        wr(3'd0, tpk(0, 0, 0, 10));
        tick(3);
        rd(3'd0, v); chk("R3 three bypass ticks", v, tpk(0, 0, 0, 13));
        rd(3'd5, v); chk("R5 second event", v & 32'h1, 1);
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        wr(3'd1, tpk(100, 12, 0, 0));
        wr(3'd0, tpk(5, 23, 59, 59));
        wr(3'd5, 32'h7f);
        tick(1);
        rd(3'd0, v); chk("R4 full carry", v, tpk(6, 0, 0, 0));
        rd(3'd5, v); chk("R5 all four tick events", v, 32'h0f);
        wr(3'd0, tpk(6, 0, 0, 59));
        wr(3'd5, 32'h7f);
        tick(1);
        rd(3'd5, v); chk("R5 minute only", v, 32'h03);
        wr(3'd0, tpk(32767, 23, 59, 59));
        tick(1);
        rd(3'd0, v); chk("R4 day wrap", v, tpk(0, 0, 0, 0));
    endtask

    task automatic t_alarms();
        logic [31:0] v;
        wr(3'd1, tpk(9, 1, 2, 3));
        wr(3'd0, tpk(2, 1, 2, 2));
        wr(3'd5, 32'h7f);
        tick(1);
        rd(3'd5, v); chk("R6 alarm on other day", v, 32'h21);
        wr(3'd0, tpk(9, 1, 2, 2));
        wr(3'd5, 32'h7f);
        tick(1);
        rd(3'd5, v); chk("R7 day plus time alarm", v, 32'h61);
        wr(3'd5, 32'h7f);
        @(negedge clk);
        addr = 3'd0; wdata = tpk(9, 1, 2, 3); wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        rd(3'd0, v); chk("R12 write beats tick", v, tpk(9, 1, 2, 3));
        rd(3'd5, v); chk("R12 write does not alarm", v & 32'h60, 0);
    endtask

    task automatic t_stopwatch();
        logic [31:0] v;
        wr(3'd1, tpk(200, 20, 0, 0));
        wr(3'd3, 32'h2);
        wr(3'd2, 3);
        wr(3'd5, 32'h7f);
        tick(2);
        rd(3'd2, v); chk("R8 counting down", v, 1);
        rd(3'd5, v); chk("R8 not yet expired", v & 32'h10, 0);
        tick(1);
        rd(3'd2, v); chk("R8 reached zero", v, 0);
        rd(3'd5, v); chk("R8 expiry event", v & 32'h10, 32'h10);
        wr(3'd5, 32'h10);
        tick(2);
        rd(3'd2, v); chk("R8 stays at zero", v, 0);
        rd(3'd5, v); chk("R8 no second expiry", v & 32'h10, 0);
        wr(3'd3, 0);
        wr(3'd2, 5);
        tick(3);
        rd(3'd2, v); chk("R8 held while stopped", v, 5);
    endtask

    task automatic t_status();
        logic [31:0] v;
        wr(3'd5, 32'h7f);
        tick(1);
        wr(3'd5, 0);
        rd(3'd5, v); chk("R9 write zero keeps bit", v & 32'h1, 1);
        wr(3'd5, 1);
        rd(3'd5, v); chk("R9 write one clears", v & 32'h1, 0);
        @(negedge clk);
        addr = 3'd5; wdata = 1; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        rd(3'd5, v); chk("R9 event beats clear", v & 32'h1, 1);
    endtask

    task automatic t_irq_wake();
        wr(3'd4, 0);
        wr(3'd5, 32'h7f);
        tick(1);
        chk("R11 disabled event no wake", wake, 0);
        chk("R10 disabled status no irq", irq, 0);
        wr(3'd5, 32'h7f);
        wr(3'd4, 1);
        chk("R10 irq low before event", irq, 0);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        chk("R11 wake pulse", wake, 1);
        chk("R10 irq set", irq, 1);
        @(negedge clk);
        chk("R11 wake one cycle", wake, 0);
        chk("R10 irq level holds", irq, 1);
        wr(3'd4, 0);
        chk("R10 irq drops with enable", irq, 0);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        wr(3'd3, 1);
        wr(3'd0, 0);
        tick(32767);
        rd(3'd0, v); chk("R2 no second after 32767", v, 0);
        tick(1);
        rd(3'd0, v); chk("R2 one second after 32768", v, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_cascade();
        t_alarms();
        t_stopwatch();
        t_status();
        t_irq_wake();
        t_divider();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule